// File: doc/BRIEF.md
# Bit-Timed High/Low Pulse Encoder

This block turns a stream of bytes into a waveform on a single wire. Each data bit becomes one bit cell. The cell opens with the line driven high, drops to low after a programmed number of clock ticks, and closes after a second programmed number of ticks. The bit's value picks which of two (high time, period) pairs governs the cell. Both thresholds are counted from the cell's first clock, so each period is a total length from the start of the cell and not a separate low duration.

Bytes enter over a valid/ready stream whose `last` flag closes a transfer. Within a transfer, bits leave most significant first and cells follow one another with no idle clock between them. A single-entry look-ahead register takes the following byte during the final cell of the current one. The four timing inputs are captured only when a transfer begins. After the final cell of the byte flagged last, the line rests low and a one-clock completion pulse is raised.

Top module: `pulse_stream_encoder`

## Requirements
- R1: After synchronous reset, `pulse_out`, `busy` and `done` are 0 and `s_ready` is 1.
- R2: A cell with high time H and effective period P drives `pulse_out` to 1 for its first H clocks and to 0 for the remaining P-H clocks. The first cell of a transfer begins in the clock after the byte is accepted while idle.
- R3: A bit value of 0 uses `cfg_hi0`/`cfg_per0`, and a bit value of 1 uses `cfg_hi1`/`cfg_per1`.
- R4: Each byte produces exactly 8 cells, sent from bit 7 down to bit 0.
- R5: While a transfer runs, `s_ready` is 1 only during bit 0's cell of a byte not flagged last, and only until a byte is taken. A byte taken there starts its first cell in the clock right after the previous cell ends, with no gap.
- R6: A configured period less than or equal to its high time is treated as that high time plus one.
- R7: The timing inputs are captured when the first byte of a transfer is accepted. Changes to them during the transfer, including during a starved wait, have no effect on that transfer.
- R8: `done` is 1 for exactly one clock, in the clock after the last cell of the byte flagged last. In that clock `busy` is 0.
- R9: Whenever `busy` is 0, `pulse_out` is 0. If no byte is ready when a non-final byte's last cell ends, the block holds `pulse_out` at 0 with `busy` at 1 and `s_ready` at 1, and the next accepted byte starts its cells in the following clock.
- R10: `s_ready` is 1 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hi0 | input | TICK_W | High ticks for a 0 bit |
| cfg_per0 | input | TICK_W | Total cell ticks for a 0 bit |
| cfg_hi1 | input | TICK_W | High ticks for a 1 bit |
| cfg_per1 | input | TICK_W | Total cell ticks for a 1 bit |
| s_valid | input | 1 | Byte on `s_data` is offered |
| s_data | input | DATA_W | Byte to encode |
| s_last | input | 1 | Offered byte closes the transfer |
| s_ready | output | 1 | Block takes the offered byte at this edge |
| pulse_out | output | 1 | Encoded line level |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that the stream source keeps `s_data` and `s_last` steady while `s_valid` waits for `s_ready`. They also assume that every transfer is eventually closed by a byte flagged last. The bench offers a byte only after it has seen `s_ready` high and then holds that byte for exactly one edge, so no offer is ever withdrawn or changed. Every transfer the bench sends ends in a flagged byte. The starved case is reached by delaying the second byte well past the first byte's eight cells.

// File: rtl/pulse_enc_pkg.sv
package pulse_enc_pkg;

    // Sequencer states: idle waits for a first byte, run emits cells,
    // starve holds the line low inside a transfer while no byte is ready.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_STARVE = 2'd2
    } enc_state_e;

    // Index of the (high, period) pair used for each bit value.
    localparam int PAIR_ZERO = 0;
    localparam int PAIR_ONE  = 1;
    localparam int NUM_PAIRS = 2;

    // Pair index chosen by a bit value.
    function automatic int pair_of(input logic bit_val);
        return bit_val ? PAIR_ONE : PAIR_ZERO;
    endfunction

endpackage

// File: rtl/pe_timing_latch.sv
module pe_timing_latch #(
    parameter int TICK_W = 16,
    localparam int PER_W = TICK_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TICK_W-1:0] raw_hi  [pulse_enc_pkg::NUM_PAIRS],
    input  logic [TICK_W-1:0] raw_per [pulse_enc_pkg::NUM_PAIRS],
    output logic [TICK_W-1:0] eff_hi  [pulse_enc_pkg::NUM_PAIRS],
    output logic [PER_W-1:0]  eff_per [pulse_enc_pkg::NUM_PAIRS]
);
    import pulse_enc_pkg::*;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [PER_W-1:0] per_fixed;

        // A period that does not exceed its high time grows to high + 1,
        // so every cell ends with at least one low clock.
        always_comb begin
            if (raw_per[g] <= raw_hi[g])
                per_fixed = {1'b0, raw_hi[g]} + PER_W'(1);
            else
                per_fixed = {1'b0, raw_per[g]};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                eff_hi[g]  <= '0;
                eff_per[g] <= PER_W'(1);
            end else if (load) begin
                eff_hi[g]  <= raw_hi[g];
                eff_per[g] <= per_fixed;
            end
        end

        p_period_exceeds_high_r6: assert property (@(posedge clk) disable iff (rst)
            eff_per[g] > {1'b0, eff_hi[g]});

        p_held_without_load_r7: assert property (@(posedge clk) disable iff (rst)
            !load |=> ($stable(eff_hi[g]) && $stable(eff_per[g])));
    end

endmodule

// File: rtl/pe_cell_timer.sv
module pe_cell_timer #(
    parameter int TICK_W = 16,
    localparam int PER_W = TICK_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [TICK_W-1:0] hi_sel,
    input  logic [PER_W-1:0]  per_sel,
    output logic              cell_end,
    output logic              level
);
    logic [PER_W-1:0] elapsed;

    // Both thresholds compare against one counter that restarts at each cell.
    assign cell_end = active && (elapsed == per_sel - PER_W'(1));
    assign level    = active && (elapsed < {1'b0, hi_sel});

    always_ff @(posedge clk) begin
        if (rst || !active || cell_end)
            elapsed <= '0;
        else
            elapsed <= elapsed + PER_W'(1);
    end

    p_count_in_cell_r2: assert property (@(posedge clk) disable iff (rst)
        active |-> (elapsed < per_sel));

    p_restart_after_end_r5: assert property (@(posedge clk) disable iff (rst)
        cell_end |=> (elapsed == '0));

endmodule

// File: rtl/pe_byte_sequencer.sv
module pe_byte_sequencer #(
    parameter int DATA_W = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              cell_end,
    output logic              active,
    output logic              cur_bit,
    output logic              cfg_load,
    output logic              busy,
    output logic              done
);
    import pulse_enc_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

    enc_state_e        state;
    logic [DATA_W-1:0] cur_byte;
    logic              cur_last;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] nxt_byte;
    logic              nxt_last;
    logic              nxt_valid;
    logic              accept;
    logic              final_cell;
    logic              frame_end;

    assign final_cell = (bit_idx == '0);
    assign active     = (state == ST_RUN);
    assign busy       = (state != ST_IDLE);
    assign cur_bit    = cur_byte[DATA_W-1];

    // The look-ahead slot opens only in the final cell of a non-last byte.
    assign s_ready    = (state != ST_RUN) ||
                        (final_cell && !cur_last && !nxt_valid);
    assign accept     = s_valid && s_ready;
    assign cfg_load   = accept && (state == ST_IDLE);
    assign frame_end  = active && cell_end && final_cell && cur_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_byte  <= '0;
            cur_last  <= 1'b0;
            bit_idx   <= '0;
            nxt_byte  <= '0;
            nxt_last  <= 1'b0;
            nxt_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= frame_end;
            unique case (state)
                ST_IDLE, ST_STARVE: begin
                    if (accept) begin
                        cur_byte <= s_data;
                        cur_last <= s_last;
                        bit_idx  <= TOP_IDX;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cell_end) begin
                        if (!final_cell) begin
                            cur_byte <= cur_byte << 1;
                            bit_idx  <= bit_idx - IDX_W'(1);
                        end else if (cur_last) begin
                            state <= ST_IDLE;
                        end else if (nxt_valid) begin
                            cur_byte  <= nxt_byte;
                            cur_last  <= nxt_last;
                            bit_idx   <= TOP_IDX;
                            nxt_valid <= 1'b0;
                        end else if (accept) begin
                            cur_byte <= s_data;
                            cur_last <= s_last;
                            bit_idx  <= TOP_IDX;
                        end else begin
                            state <= ST_STARVE;
                        end
                    end else if (accept) begin
                        nxt_byte  <= s_data;
                        nxt_last  <= s_last;
                        nxt_valid <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_while_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_slot_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (nxt_valid && !cell_end) |=> nxt_valid);

    p_no_slot_outside_run_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> !nxt_valid);

endmodule

// File: rtl/pulse_stream_encoder.sv
module pulse_stream_encoder #(
    parameter int TICK_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] cfg_hi0,
    input  logic [TICK_W-1:0] cfg_per0,
    input  logic [TICK_W-1:0] cfg_hi1,
    input  logic [TICK_W-1:0] cfg_per1,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              pulse_out,
    output logic              busy,
    output logic              done
);
    import pulse_enc_pkg::*;

    localparam int PER_W = TICK_W + 1;

    logic [TICK_W-1:0] raw_hi  [NUM_PAIRS];
    logic [TICK_W-1:0] raw_per [NUM_PAIRS];
    logic [TICK_W-1:0] eff_hi  [NUM_PAIRS];
    logic [PER_W-1:0]  eff_per [NUM_PAIRS];
    logic              cfg_load;
    logic              active;
    logic              cur_bit;
    logic              cell_end;
    logic [TICK_W-1:0] hi_sel;
    logic [PER_W-1:0]  per_sel;

    assign raw_hi[PAIR_ZERO]  = cfg_hi0;
    assign raw_per[PAIR_ZERO] = cfg_per0;
    assign raw_hi[PAIR_ONE]   = cfg_hi1;
    assign raw_per[PAIR_ONE]  = cfg_per1;

    assign hi_sel  = eff_hi[pair_of(cur_bit)];
    assign per_sel = eff_per[pair_of(cur_bit)];

    pe_timing_latch #(.TICK_W(TICK_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .raw_hi  (raw_hi),
        .raw_per (raw_per),
        .eff_hi  (eff_hi),
        .eff_per (eff_per)
    );

    pe_byte_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .cell_end (cell_end),
        .active   (active),
        .cur_bit  (cur_bit),
        .cfg_load (cfg_load),
        .busy     (busy),
        .done     (done)
    );

    pe_cell_timer #(.TICK_W(TICK_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .hi_sel   (hi_sel),
        .per_sel  (per_sel),
        .cell_end (cell_end),
        .level    (pulse_out)
    );

    p_idle_line_low_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pulse_out);

    p_ready_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> s_ready);

endmodule

// File: tb/pulse_stream_encoder_tb.sv
module pulse_stream_encoder_tb;
    localparam int TICK_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TICK_W-1:0] cfg_hi0 = '0, cfg_per0 = '0, cfg_hi1 = '0, cfg_per1 = '0;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              s_ready, pulse_out, busy, done;

    always #5 clk = ~clk;

    pulse_stream_encoder #(.TICK_W(TICK_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_hi0(cfg_hi0), .cfg_per0(cfg_per0), .cfg_hi1(cfg_hi1), .cfg_per1(cfg_per1),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .pulse_out(pulse_out), .busy(busy), .done(done)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    done_seen = 0;
    int    frames_sent = 0;
    logic  prev_busy = 1'b0;
    logic  exp_q[$];
    string cell_tag = "R2";
    logic [7:0] frame_buf [8];

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected line levels, one entry per clock, for one byte (R3, R4, R6).
    task automatic push_byte(input logic [7:0] b, input int h0, input int p0,
                             input int h1, input int p1);
        for (int i = 7; i >= 0; i--) begin
            int hi = b[i] ? h1 : h0;
            int per = b[i] ? p1 : p0;
            if (per <= hi) per = hi + 1;
            for (int c = 0; c < per; c++) exp_q.push_back(c < hi);
        end
    endtask

    // Monitor: compares the line each clock against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                done_seen++;
                check(!busy && exp_q.size() == 0 && prev_busy, "R8 done timing",
                      {busy, prev_busy}, 1);
            end
            if (busy) begin
                logic e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
                check(pulse_out == e, cell_tag, pulse_out, e);
            end else begin
                check(!pulse_out, "R9 idle low", pulse_out, 0);
            end
            prev_busy = busy;
        end
    end

    // Driver: sends frame_buf[0..n-1]; optional scramble of the timing
    // inputs after the first byte (R7) and gap before the second (R9).
    task automatic send_frame(input int n, input bit scramble, input int gap);
        int h0 = cfg_hi0, p0 = cfg_per0, h1 = cfg_hi1, p1 = cfg_per1;
        for (int k = 0; k < n; k++) begin
            forever begin
                @(posedge clk); #1;
                if (s_ready) break;
            end
            s_valid = 1'b1;
            s_data  = frame_buf[k];
            s_last  = (k == n - 1);
            @(posedge clk); #1;
            s_valid = 1'b0;
            push_byte(frame_buf[k], h0, p0, h1, p1);
            if (k == 0 && scramble) begin
                cfg_hi0 = 16'd1; cfg_per0 = 16'd30; cfg_hi1 = 16'd25; cfg_per1 = 16'd3;
            end
            if (k == 0 && gap > 0) begin
                repeat (gap) @(posedge clk);
                #1;
                check(busy && s_ready && !pulse_out, "R9 starve hold",
                      {busy, s_ready, pulse_out}, 6);
            end
        end
        frames_sent++;
        forever begin
            @(negedge clk);
            if (!busy && exp_q.size() == 0) break;
        end
        @(negedge clk);
        check(done_seen == frames_sent, "R8 done count", done_seen, frames_sent);
        check(s_ready == 1'b1, "R10 ready idle", s_ready, 1);
    endtask

    task automatic set_cfg(input int h0, input int p0, input int h1, input int p1);
        cfg_hi0 = TICK_W'(h0); cfg_per0 = TICK_W'(p0);
        cfg_hi1 = TICK_W'(h1); cfg_per1 = TICK_W'(p1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!pulse_out && !busy && !done && s_ready, "R1 reset outputs",
              {pulse_out, busy, done, s_ready}, 1);

        // R2 R3 R4 R5: two bytes back to back, mixed bits
        cell_tag = "R2/R3/R4/R5 two-byte frame";
        set_cfg(3, 8, 6, 9);
        frame_buf[0] = 8'hA5; frame_buf[1] = 8'h3C;
        send_frame(2, 1'b0, 0);

        // R3 R4: all-ones, all-zeros, single MSB, single LSB
        cell_tag = "R3/R4 pattern frame";
        set_cfg(2, 5, 4, 5);
        frame_buf[0] = 8'hFF; frame_buf[1] = 8'h00;
        frame_buf[2] = 8'h80; frame_buf[3] = 8'h01;
        send_frame(4, 1'b0, 0);

        // R6: periods at or below high time
        cell_tag = "R6 normalised period";
        set_cfg(4, 4, 7, 2);
        frame_buf[0] = 8'h5A;
        send_frame(1, 1'b0, 0);

        // R6: zero high, zero period gives a single low clock
        cell_tag = "R6 zero high";
        set_cfg(0, 0, 3, 6);
        frame_buf[0] = 8'hC3; frame_buf[1] = 8'h96;
        send_frame(2, 1'b0, 0);

        // R7: timing inputs changed after the first byte
        cell_tag = "R7 mid-transfer change";
        set_cfg(2, 6, 5, 7);
        frame_buf[0] = 8'h69; frame_buf[1] = 8'hF0; frame_buf[2] = 8'h0F;
        send_frame(3, 1'b1, 0);

        // R9 R7: starved wait between bytes, inputs also changed
        cell_tag = "R9 starve resume";
        set_cfg(3, 7, 5, 8);
        frame_buf[0] = 8'hB2; frame_buf[1] = 8'h4D;
        send_frame(2, 1'b1, 120);

        // R8: single-byte frame
        cell_tag = "R8 single byte";
        set_cfg(1, 3, 2, 4);
        frame_buf[0] = 8'h81;
        send_frame(1, 1'b0, 0);

        repeat (5) @(negedge clk);
        check(!pulse_out && !busy && !done, "R9 final idle", {pulse_out, busy, done}, 0);
        finish_run();
    end

endmodule